// File: doc/BRIEF.md
# Reset Cause Controller

This unit sits beside the processor of a small 8-bit controller and turns every reset request into one clean internal system reset. Requests come in as strobes or levels: the power-on detector, the active-low external reset pin, the watchdog timeout, the illegal-instruction detector, the clock-loss monitor, the low-voltage comparator, and a reset forced from the debug port. While any request is live, and for a fixed stretch after the last one goes away, the system reset output stays high.

When a reset episode begins, the unit records which sources were live into a read-only cause byte. Firmware reads that byte over a simple register bus after it restarts. The bus also carries two side effects. A write of any value to the cause address restarts the watchdog. A separate force register accepts only writes that come from the debug port, and bit 0 of such a write starts a reset. The power-on detector also acts as the unit's own asynchronous reset, so only power-on restores the cause byte to its power-on value.

Top module: `rst_cause_ctrl`

## Requirements
- R1: While `por_det` is high and after it falls, the cause byte reads 0x82: bit 7 (power-on) and bit 1 (low voltage) are both set, and `sys_rst` is high.
- R2: `sys_rst` rises on the clock edge that first samples a request. It stays high while requests continue, and for exactly STRETCH_CYC (32) cycles after the last edge that samples a request.
- R3: On the edge that opens a reset episode, the cause byte is rewritten. Each source active then sets its bit (bit 6 pin, bit 5 watchdog, bit 4 illegal instruction, bit 2 clock loss, bit 1 low voltage). Every other bit clears, and bits 3 and 0 always read 0. The byte does not change at any other time.
- R4: A low level on `ext_rst_n` passes through a SYNC_STAGES (2) flop synchronizer and then raises a reset with cause 0x40. After the pin returns high, `sys_rst` stays high for STRETCH_CYC+SYNC_STAGES samples.
- R5: `wdog_timeout` raises a reset with cause bit 5 only while `wdog_en` is 1. When `wdog_en` is 0 the timeout is ignored: there is no reset and the cause byte is unchanged.
- R6: `illop_det` raises a reset with cause bit 4. So does `stop_exec` while `stop_en` is 0, and `bgnd_exec` while `bgnd_en` is 0. `stop_exec` and `bgnd_exec` are ignored while their enable is 1.
- R7: `lv_trip` raises a reset with cause bit 1 only when `lvr_en` and `lvs_en` are both 1. Otherwise it is ignored.
- R8: `clk_lost` raises a reset with cause bit 2.
- R9: A bus write of any data to STAT_ADDR (0x00) makes `wdog_restart` high for the single cycle after the write edge. It leaves the cause byte unchanged.
- R10: The force register at FORCE_ADDR (0x01) always reads 0x00. A write with `bus_dbg`=1 and data bit 0 set raises a reset with cause 0x00. Writes with `bus_dbg`=0, and debug writes with bit 0 clear, are ignored.
- R11: `bus_rdata` is 0x00 whenever `bus_re` is 0 or the address is neither STAT_ADDR nor FORCE_ADDR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Unit clock |
| por_det | input | 1 | Power-on detect, active high, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdog_timeout | input | 1 | Watchdog timeout strobe |
| wdog_en | input | 1 | Watchdog reset enable |
| illop_det | input | 1 | Illegal instruction strobe from the decoder |
| stop_exec | input | 1 | Stop instruction executed |
| stop_en | input | 1 | Stop instruction allowed |
| bgnd_exec | input | 1 | Background-entry instruction executed |
| bgnd_en | input | 1 | Background mode allowed |
| clk_lost | input | 1 | Clock-loss monitor request |
| lv_trip | input | 1 | Low-voltage comparator trip |
| lvr_en | input | 1 | Low-voltage reset enable |
| lvs_en | input | 1 | Low-voltage sense enable |
| bus_addr | input | ADDR_W (8) | Register bus address |
| bus_wdata | input | 8 | Register bus write data |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| bus_dbg | input | 1 | Current access comes from the debug port |
| bus_rdata | output | 8 | Read data, combinational |
| wdog_restart | output | 1 | One-cycle watchdog restart pulse |
| sys_rst | output | 1 | Stretched internal system reset |

## Verification
The hardest cases to reach from the ports are the ones where a source is live but gated by its enables. In those cases nothing may happen: no reset pulse, and the cause byte keeps the value from an earlier episode. Seeded random trials drive random mixes of sources and enables. A bench model decides whether each trial fires. It checks either the exact 32-sample stretch and the new cause byte, or a silent `sys_rst` and an untouched cause byte. Directed cases cover the synchronizer delay on the pin, writes to the force register from each port, and writes to the cause address that only restart the watchdog.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

   // cause byte bit positions (firmware decodes these)
   localparam int unsigned CB_POR   = 7;
   localparam int unsigned CB_PIN   = 6;
   localparam int unsigned CB_WDOG  = 5;
   localparam int unsigned CB_ILLOP = 4;
   localparam int unsigned CB_LOC   = 2;
   localparam int unsigned CB_LVD   = 1;

   // data bit of a debug write that triggers a forced reset
   localparam int unsigned FORCE_BIT = 0;

   localparam logic [7:0] CAUSE_POR = 8'h82;

   typedef struct packed {
      logic pin;
      logic wdog;
      logic illop;
      logic loc;
      logic lvd;
      logic dbg;
   } rcc_req_t;

   function automatic logic [7:0] cause_of(input rcc_req_t r);
      logic [7:0] c;
      c           = '0;
      c[CB_PIN]   = r.pin;
      c[CB_WDOG]  = r.wdog;
      c[CB_ILLOP] = r.illop;
      c[CB_LOC]   = r.loc;
      c[CB_LVD]   = r.lvd;
      return c;
   endfunction

endpackage

// File: rtl/rcc_sync.sv
module rcc_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic arst,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] stg_q;
         always_ff @(posedge clk or posedge arst) begin
            if (arst) stg_q <= {STAGES{RST_VAL}};
            else      stg_q <= {stg_q[STAGES-2:0], d};
         end
         assign q = stg_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/rcc_qual.sv
module rcc_qual
   import rcc_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter logic [ADDR_W-1:0] FORCE_ADDR = 8'h01
) (
   input  logic              clk,
   input  logic              arst,
   input  logic              pin_sync_n,
   input  logic              wdog_timeout,
   input  logic              wdog_en,
   input  logic              illop_det,
   input  logic              stop_exec,
   input  logic              stop_en,
   input  logic              bgnd_exec,
   input  logic              bgnd_en,
   input  logic              clk_lost,
   input  logic              lv_trip,
   input  logic              lvr_en,
   input  logic              lvs_en,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic              bus_dbg,
   input  logic              force_dat,
   output rcc_req_t          req,
   output logic              req_any
);

   logic hit_force;
   logic stop_bad;
   logic bgnd_bad;

   assign hit_force = (bus_addr == FORCE_ADDR);
   assign stop_bad  = stop_exec & ~stop_en;
   assign bgnd_bad  = bgnd_exec & ~bgnd_en;

   always_comb begin
      req       = '0;
      req.pin   = ~pin_sync_n;
      req.wdog  = wdog_timeout & wdog_en;
      req.illop = illop_det | stop_bad | bgnd_bad;
      req.loc   = clk_lost;
      req.lvd   = lv_trip & lvr_en & lvs_en;
      req.dbg   = bus_we & bus_dbg & hit_force & force_dat;
   end

   assign req_any = |req;

   // processor-side writes never reach the force path
   assert_cpu_force_R10: assert property (@(posedge clk) disable iff (arst)
      (bus_we && !bus_dbg) |-> !req.dbg);

   // a gated watchdog timeout produces no request
   assert_wdog_gate_R5: assert property (@(posedge clk) disable iff (arst)
      (!wdog_en && pin_sync_n && !illop_det && !stop_bad && !bgnd_bad
       && !clk_lost && !lv_trip && !bus_we) |-> !req_any);

endmodule

// File: rtl/rcc_stretch.sv
module rcc_stretch #(
   parameter int unsigned STRETCH_CYC = 32
) (
   input  logic clk,
   input  logic arst,
   input  logic req_any,
   output logic rst_o
);

   localparam int unsigned CNT_W = $clog2(STRETCH_CYC + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STRETCH_CYC);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or posedge arst) begin
      if (arst)             cnt_q <= CNT_LOAD;
      else if (req_any)     cnt_q <= CNT_LOAD;
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign rst_o = (cnt_q != '0);

   // independent count of request-free cycles
   logic [CNT_W-1:0] quiet_q;
   always_ff @(posedge clk or posedge arst) begin
      if (arst)                     quiet_q <= '0;
      else if (req_any)             quiet_q <= '0;
      else if (quiet_q != CNT_LOAD) quiet_q <= quiet_q + 1'b1;
   end

   assert_hold_R2: assert property (@(posedge clk) disable iff (arst)
      req_any |=> rst_o);

   assert_release_R2: assert property (@(posedge clk) disable iff (arst)
      $fell(rst_o) |-> !$past(req_any));

   assert_length_R2: assert property (@(posedge clk) disable iff (arst)
      rst_o == (quiet_q != CNT_LOAD));

endmodule

// File: rtl/rcc_regs.sv
module rcc_regs
   import rcc_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter logic [ADDR_W-1:0] STAT_ADDR  = 8'h00,
   parameter logic [ADDR_W-1:0] FORCE_ADDR = 8'h01
) (
   input  logic              clk,
   input  logic              arst,
   input  logic              latch_en,
   input  logic [7:0]        new_cause,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic              bus_re,
   output logic [7:0]        bus_rdata,
   output logic              wdog_restart,
   output logic [7:0]        cause_o
);

   logic [7:0] cause_q;
   logic       restart_q;
   logic       hit_stat;
   logic       hit_force;

   assign hit_stat  = (bus_addr == STAT_ADDR);
   assign hit_force = (bus_addr == FORCE_ADDR);

   always_ff @(posedge clk or posedge arst) begin
      if (arst)          cause_q <= CAUSE_POR;
      else if (latch_en) cause_q <= new_cause;
   end

   always_ff @(posedge clk or posedge arst) begin
      if (arst) restart_q <= 1'b0;
      else      restart_q <= bus_we & hit_stat;
   end

   always_comb begin
      bus_rdata = 8'h00;
      if (bus_re) begin
         if (hit_stat)       bus_rdata = cause_q;
         else if (hit_force) bus_rdata = 8'h00;
      end
   end

   assign wdog_restart = restart_q;
   assign cause_o      = cause_q;

   assert_restart_R9: assert property (@(posedge clk) disable iff (arst)
      (bus_we && bus_addr == STAT_ADDR) |=> wdog_restart);

   assert_restart_src_R9: assert property (@(posedge clk) disable iff (arst)
      wdog_restart |-> $past(bus_we && bus_addr == STAT_ADDR));

   assert_force_read_R10: assert property (@(posedge clk) disable iff (arst)
      (bus_re && bus_addr == FORCE_ADDR) |-> bus_rdata == 8'h00);

   assert_unmapped_R11: assert property (@(posedge clk) disable iff (arst)
      (!bus_re || (bus_addr != STAT_ADDR && bus_addr != FORCE_ADDR))
      |-> bus_rdata == 8'h00);

endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
   import rcc_pkg::*;
#(
   parameter int unsigned STRETCH_CYC = 32,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = 8,
   parameter logic [ADDR_W-1:0] STAT_ADDR  = 8'h00,
   parameter logic [ADDR_W-1:0] FORCE_ADDR = 8'h01
) (
   input  logic              clk,
   input  logic              por_det,
   input  logic              ext_rst_n,
   input  logic              wdog_timeout,
   input  logic              wdog_en,
   input  logic              illop_det,
   input  logic              stop_exec,
   input  logic              stop_en,
   input  logic              bgnd_exec,
   input  logic              bgnd_en,
   input  logic              clk_lost,
   input  logic              lv_trip,
   input  logic              lvr_en,
   input  logic              lvs_en,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   input  logic              bus_we,
   input  logic              bus_re,
   input  logic              bus_dbg,
   output logic [7:0]        bus_rdata,
   output logic              wdog_restart,
   output logic              sys_rst
);

   generate
      if (STRETCH_CYC < 1) begin : g_bad_stretch
         $error("STRETCH_CYC must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (STAT_ADDR == FORCE_ADDR) begin : g_bad_map
         $error("STAT_ADDR and FORCE_ADDR must differ");
      end
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_aw
         $error("ADDR_W out of range");
      end
   endgenerate

   logic       pin_sync_n;
   rcc_req_t   req;
   logic       req_any;
   logic       latch_en;
   logic [7:0] cause;
   logic       unused_wdata;

   assign unused_wdata = ^{bus_wdata[7:FORCE_BIT+1]};

   rcc_sync #(
      .STAGES (SYNC_STAGES),
      .RST_VAL(1'b1)
   ) u_pin_sync (
      .clk (clk),
      .arst(por_det),
      .d   (ext_rst_n),
      .q   (pin_sync_n)
   );

   rcc_qual #(
      .ADDR_W    (ADDR_W),
      .FORCE_ADDR(FORCE_ADDR)
   ) u_qual (
      .clk         (clk),
      .arst        (por_det),
      .pin_sync_n  (pin_sync_n),
      .wdog_timeout(wdog_timeout),
      .wdog_en     (wdog_en),
      .illop_det   (illop_det),
      .stop_exec   (stop_exec),
      .stop_en     (stop_en),
      .bgnd_exec   (bgnd_exec),
      .bgnd_en     (bgnd_en),
      .clk_lost    (clk_lost),
      .lv_trip     (lv_trip),
      .lvr_en      (lvr_en),
      .lvs_en      (lvs_en),
      .bus_addr    (bus_addr),
      .bus_we      (bus_we),
      .bus_dbg     (bus_dbg),
      .force_dat   (bus_wdata[FORCE_BIT]),
      .req         (req),
      .req_any     (req_any)
   );

   rcc_stretch #(
      .STRETCH_CYC(STRETCH_CYC)
   ) u_stretch (
      .clk    (clk),
      .arst   (por_det),
      .req_any(req_any),
      .rst_o  (sys_rst)
   );

   // cause is captured on the first edge of an episode only
   assign latch_en = req_any & ~sys_rst;

   rcc_regs #(
      .ADDR_W    (ADDR_W),
      .STAT_ADDR (STAT_ADDR),
      .FORCE_ADDR(FORCE_ADDR)
   ) u_regs (
      .clk         (clk),
      .arst        (por_det),
      .latch_en    (latch_en),
      .new_cause   (cause_of(req)),
      .bus_addr    (bus_addr),
      .bus_we      (bus_we),
      .bus_re      (bus_re),
      .bus_rdata   (bus_rdata),
      .wdog_restart(wdog_restart),
      .cause_o     (cause)
   );

   assert_cause_stable_R3: assert property (@(posedge clk) disable iff (por_det)
      !(req_any && !sys_rst) |=> $stable(cause));

   assert_reserved_R3: assert property (@(posedge clk) disable iff (por_det)
      cause[3] == 1'b0 && cause[0] == 1'b0);

   assert_episode_open_R3: assert property (@(posedge clk) disable iff (por_det)
      (req_any && !sys_rst) |=> sys_rst);

endmodule

// File: tb/rst_cause_ctrl_tb.sv
`timescale 1ns/1ps
module rst_cause_ctrl_tb;

   localparam logic [7:0] A_STAT  = 8'h00;
   localparam logic [7:0] A_FORCE = 8'h01;
   localparam int STRETCH = 32;
   localparam int SYNC    = 2;

   logic clk = 1'b0;
   logic por_det = 1'b1;
   logic ext_rst_n = 1'b1;
   logic wdog_timeout = 0, wdog_en = 0, illop_det = 0;
   logic stop_exec = 0, stop_en = 1, bgnd_exec = 0, bgnd_en = 1;
   logic clk_lost = 0, lv_trip = 0, lvr_en = 0, lvs_en = 0;
   logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
   logic bus_we = 0, bus_re = 0, bus_dbg = 0;
   logic [7:0] bus_rdata;
   logic wdog_restart, sys_rst;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   rst_cause_ctrl u_dut (
      .clk(clk), .por_det(por_det), .ext_rst_n(ext_rst_n),
      .wdog_timeout(wdog_timeout), .wdog_en(wdog_en), .illop_det(illop_det),
      .stop_exec(stop_exec), .stop_en(stop_en), .bgnd_exec(bgnd_exec),
      .bgnd_en(bgnd_en), .clk_lost(clk_lost), .lv_trip(lv_trip),
      .lvr_en(lvr_en), .lvs_en(lvs_en), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
      .bus_dbg(bus_dbg), .bus_rdata(bus_rdata),
      .wdog_restart(wdog_restart), .sys_rst(sys_rst)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] v);
      bus_addr = a; bus_re = 1'b1;
      #1 v = bus_rdata;
      bus_re = 1'b0;
   endtask

   // called at a negedge: counts samples with sys_rst high
   task automatic count_rst(output int n);
      n = 0;
      while (sys_rst === 1'b1 && n < 200) begin
         n++;
         @(negedge clk);
      end
   endtask

   // watches sys_rst for k negedges, returns 1 if it ever rose
   task automatic watch_quiet(input int k, output bit seen);
      seen = 0;
      for (int i = 0; i < k; i++) begin
         if (sys_rst !== 1'b0) seen = 1;
         @(negedge clk);
      end
   endtask

   task automatic drop_all();
      wdog_timeout = 0; illop_det = 0; stop_exec = 0; bgnd_exec = 0;
      clk_lost = 0; lv_trip = 0;
   endtask

   function automatic logic [8:0] model(
      input bit wto, input bit wen, input bit il, input bit sx, input bit sen,
      input bit bx, input bit ben, input bit lc, input bit lt, input bit lre,
      input bit lse);
      logic [7:0] c;
      c = 8'h00;
      c[5] = wto & wen;
      c[4] = il | (sx & ~sen) | (bx & ~ben);
      c[2] = lc;
      c[1] = lt & lre & lse;
      return {|c, c};
   endfunction

   initial begin
      logic [7:0] v, prev;
      int n;
      bit seen;
      void'($urandom(32'd2024));

      // R1: power-on
      repeat (3) @(negedge clk);
      chk("R1 sys_rst in por", sys_rst, 1);
      rd(A_STAT, v); chk("R1 cause in por", v, 8'h82);
      por_det = 0;
      count_rst(n); chk("R2 stretch after por", n, STRETCH);
      rd(A_STAT, v); chk("R1 cause after por", v, 8'h82);

      // R11: unmapped and no read enable
      bus_addr = 8'h07; bus_re = 1; #1 chk("R11 unmapped", bus_rdata, 0); bus_re = 0;
      bus_addr = A_STAT; #1 chk("R11 re low", bus_rdata, 0);
      rd(A_FORCE, v); chk("R10 force reads zero", v, 0);

      // R9: watchdog restart
      @(negedge clk);
      bus_addr = A_STAT; bus_wdata = 8'h5A; bus_we = 1;
      @(posedge clk); #1 chk("R9 restart pulse", wdog_restart, 1);
      @(negedge clk); bus_we = 0;
      @(posedge clk); #1 chk("R9 pulse one cycle", wdog_restart, 0);
      @(negedge clk); rd(A_STAT, v); chk("R9 cause untouched", v, 8'h82);
      chk("R9 no reset", sys_rst, 0);

      // R4: pin through synchronizer
      ext_rst_n = 0;
      repeat (4) @(negedge clk);
      ext_rst_n = 1;
      count_rst(n); chk("R4 stretch with sync delay", n, STRETCH + SYNC);
      rd(A_STAT, v); chk("R4 pin cause", v, 8'h40);

      // R8 and R3: combined sources then single source clears others
      @(negedge clk);
      clk_lost = 1; wdog_timeout = 1; wdog_en = 1; lv_trip = 1; lvr_en = 1; lvs_en = 1;
      @(negedge clk); drop_all();
      count_rst(n); chk("R2 stretch combined", n, STRETCH);
      rd(A_STAT, v); chk("R3 combined cause", v, 8'h26);
      clk_lost = 1;
      @(negedge clk); drop_all();
      count_rst(n); chk("R8 stretch", n, STRETCH);
      rd(A_STAT, v); chk("R8 clock loss clears others", v, 8'h04);

      // R2: long request
      clk_lost = 1;
      repeat (10) @(negedge clk);
      drop_all();
      count_rst(n); chk("R2 stretch after long req", n, STRETCH);

      // R10: force register
      prev = 8'h04;
      bus_addr = A_FORCE; bus_wdata = 8'h01; bus_dbg = 0; bus_we = 1;
      @(negedge clk); bus_we = 0;
      watch_quiet(5, seen); chk("R10 cpu write ignored", seen, 0);
      rd(A_STAT, v); chk("R10 cause after cpu write", v, prev);
      bus_addr = A_FORCE; bus_wdata = 8'hFE; bus_dbg = 1; bus_we = 1;
      @(negedge clk); bus_we = 0;
      watch_quiet(5, seen); chk("R10 debug bit0 clear ignored", seen, 0);
      bus_addr = A_FORCE; bus_wdata = 8'h81; bus_dbg = 1; bus_we = 1;
      @(negedge clk); bus_we = 0; bus_dbg = 0;
      count_rst(n); chk("R10 forced stretch", n, STRETCH);
      rd(A_STAT, v); chk("R10 forced cause", v, 8'h00);

      // R5/R6/R7: seeded random trials against the model
      prev = 8'h00;
      for (int t = 0; t < 80; t++) begin
         bit wto, wen, il, sx, sen, bx, ben, lc, lt, lre, lse;
         logic [8:0] m;
         wto = ($urandom % 3) == 0; wen = $urandom % 2;
         il  = ($urandom % 6) == 0;
         sx  = ($urandom % 3) == 0; sen = $urandom % 2;
         bx  = ($urandom % 3) == 0; ben = $urandom % 2;
         lc  = ($urandom % 8) == 0;
         lt  = ($urandom % 3) == 0; lre = $urandom % 2; lse = $urandom % 2;
         m = model(wto, wen, il, sx, sen, bx, ben, lc, lt, lre, lse);
         wdog_timeout = wto; wdog_en = wen; illop_det = il;
         stop_exec = sx; stop_en = sen; bgnd_exec = bx; bgnd_en = ben;
         clk_lost = lc; lv_trip = lt; lvr_en = lre; lvs_en = lse;
         if (m[8]) begin
            repeat (3) @(negedge clk);
            drop_all();
            count_rst(n); chk("R5 R6 R7 random stretch", n, STRETCH);
            rd(A_STAT, v); chk("R5 R6 R7 random cause", v, {24'h0, m[7:0]});
            prev = m[7:0];
         end else begin
            @(negedge clk);
            watch_quiet(3, seen);
            drop_all();
            chk("R5 R6 R7 gated source ignored", seen, 0);
            rd(A_STAT, v); chk("R5 R6 R7 cause kept", v, {24'h0, prev});
         end
         @(negedge clk);
      end

      // R6: directed stop/bgnd with enables
      stop_exec = 1; stop_en = 1; bgnd_exec = 1; bgnd_en = 1;
      watch_quiet(3, seen); drop_all();
      chk("R6 allowed stop and bgnd ignored", seen, 0);
      bgnd_exec = 1; bgnd_en = 0;
      @(negedge clk); drop_all();
      count_rst(n); chk("R6 bgnd stretch", n, STRETCH);
      rd(A_STAT, v); chk("R6 bgnd cause", v, 8'h10);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule